// File: doc/BRIEF.md
# Register-List Stack Sequencer

This block saves or restores any subset of one eight-register bank to or from a word-addressed stack in memory. A one-cycle start pulse supplies the direction (save or restore), an eight-bit selection mask, a bank select and the current stack pointer. The sequencer then walks the mask. Each cycle it moves one register, with one memory write or read per register, and it keeps its own working copy of the stack pointer. That copy can be read at `sp_o` once the operation ends.

Mask bit `i` names register `i` of the chosen bank. The register-file address is `{bank, i}`, so the lower bank uses addresses 0 to 7 and the upper bank uses 8 to 15. A save handles set bits from bit 0 upward and lowers the pointer by one word before each write. A restore handles set bits from bit 7 downward. It reads at the pointer and then raises it by one word. Memory is a single-cycle synchronous port, so data read in one cycle is written to the register file in the next cycle. When the operation ends the block pulses `done_o` and updates its flags from the last word it moved.

Top module: `regstack_seq`

## Requirements
- R1: A save with k selected bits writes the register with the lowest selected index to address sp-1, the next selected index to sp-2, and so on. Each write data word is the register file's content at `{bank, index}`.
- R2: A restore with k selected bits loads the register with the highest selected index from address sp, the next lower selected index from sp+1, and so on. Each register-file write happens in the cycle after its memory read.
- R3: After a save `sp_o` equals sp-k. After a restore it equals sp+k, computed modulo 2^16.
- R4: Exactly one register is moved per cycle. `done_o` is high for exactly one cycle: k+1 cycles after the start cycle for a save, and k+2 cycles after it for a restore.
- R5: An all-zero mask makes no memory or register-file access, raises `done_o` in the cycle after start, and leaves all four flags unchanged.
- R6: When `done_o` rises after a non-empty operation, `zr_o` is 1 if and only if the last word moved is zero, and `ng_o` equals bit 15 of that word. `uo_o` and `so_o` are 0. The flags hold their values at all other times.
- R7: Bank select 0 addresses register-file entries 0 to 7, and bank select 1 addresses entries 8 to 15. Bits outside the mask are never touched.
- R8: A start that arrives while `busy_o` is high is ignored. The operation in progress and its results are unaffected.
- R9: After reset `busy_o`, `done_o` and all flags are 0, and no access is made.
- R10: There is never more than one memory access per cycle, and no access happens while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| pop_i | input | 1 | 1 = restore from stack, 0 = save to stack |
| mask_i | input | 8 | Register selection, bit i = bank entry i |
| bank_hi_i | input | 1 | Bank select, 1 = upper bank |
| sp_i | input | 16 | Stack pointer at start |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Working stack pointer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after the read |
| rf_raddr_o | output | 4 | Register-file read address |
| rf_rdata_i | input | 16 | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 4 | Register-file write address |
| rf_wdata_o | output | 16 | Register-file write data |
| zr_o | output | 1 | Zero flag |
| ng_o | output | 1 | Negative flag |
| uo_o | output | 1 | Unsigned overflow flag |
| so_o | output | 1 | Signed overflow flag |

## Verification
If the remaining-mask register is wrong, a register is skipped or repeated. That error is visible within one operation as a wrong memory word or register-file entry, and as a `done_o` that comes a cycle early or late. If the pointer unit is wrong, `sp_o` ends at the wrong value and every later stack slot is shifted, so the fault shows in the memory image at the end of that same operation. Errors in the restore pipeline stage send a loaded word to the neighbouring register or a cycle late. The wrong destination shows in the register-file image, and the delay moves the done pulse. Flag faults show at the done pulse, or as a flag that changes at any other time.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/regstack_pick.sv
module regstack_pick #(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  rem_i,
  input  logic             from_top_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] lo_idx, hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem_i[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rem_i[i]) hi_idx = IDX_W'(i);
    end
  end

  assign idx_o  = from_top_i ? hi_idx : lo_idx;
  assign last_o = (rem_i != '0) && ((rem_i & (rem_i - NREG'(1))) == '0);
endmodule

// File: rtl/regstack_sp.sv
module regstack_sp #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              dec_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_m1;

  assign sp_m1 = sp_q - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (dec_i)  sp_q <= sp_m1;
    else if (inc_i)  sp_q <= sp_q + ADDR_W'(1);
  end

  // save pre-decrements, restore reads at current pointer
  assign addr_o = dec_i ? sp_m1 : sp_q;
  assign sp_o   = sp_q;

  assert_step_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));
endmodule

// File: rtl/regstack_flags.sv
module regstack_flags #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              zr_o,
  output logic              ng_o,
  output logic              uo_o,
  output logic              so_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zr_o <= 1'b0;
      ng_o <= 1'b0;
      uo_o <= 1'b0;
      so_o <= 1'b0;
    end else if (upd_i) begin
      zr_o <= (val_i == '0);
      ng_o <= val_i[DATA_W-1];
      uo_o <= 1'b0;
      so_o <= 1'b0;
    end
  end

  assert_ovf_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (!uo_o && !so_o));
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import regstack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int RA_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              bank_hi_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [RA_W-1:0]   rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [RA_W-1:0]   rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              zr_o,
  output logic              ng_o,
  output logic              uo_o,
  output logic              so_o
);
  seq_state_e        state_q;
  logic [NREG-1:0]   rem_q;
  logic              pop_q, bank_q;
  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_last;
  logic              run, accept;
  logic              flag_upd;
  logic [DATA_W-1:0] flag_val;

  assign run    = (state_q == ST_RUN);
  assign accept = start_i && (state_q == ST_IDLE);

  regstack_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .rem_i      (rem_q),
    .from_top_i (pop_q),
    .idx_o      (cur_idx),
    .last_o     (cur_last)
  );

  assign mem_we_o    = run && !pop_q;
  assign mem_re_o    = run && pop_q;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = {bank_q, cur_idx};

  regstack_sp #(.ADDR_W(ADDR_W)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (sp_i),
    .dec_i      (mem_we_o),
    .inc_i      (mem_re_o),
    .sp_o       (sp_o),
    .addr_o     (mem_addr_o)
  );

  // restore: write-back stage one cycle behind the read
  assign rf_we_o    = pend_q;
  assign rf_waddr_o = {bank_q, pend_idx_q};
  assign rf_wdata_o = mem_rdata_i;

  assign flag_upd = (run && !pop_q && cur_last) || (state_q == ST_DRAIN);
  assign flag_val = pop_q ? mem_rdata_i : rf_rdata_i;

  regstack_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (flag_upd),
    .val_i  (flag_val),
    .zr_o   (zr_o),
    .ng_o   (ng_o),
    .uo_o   (uo_o),
    .so_o   (so_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      pop_q      <= 1'b0;
      bank_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= run && pop_q;
      pend_idx_q <= cur_idx;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          rem_q   <= mask_i;
          pop_q   <= pop_i;
          bank_q  <= bank_hi_i;
          state_q <= (mask_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_q & ~(NREG'(1) << cur_idx);
          if (cur_last) state_q <= pop_q ? ST_DRAIN : ST_DONE;
        end
        ST_DRAIN: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  assert_one_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o && !rf_we_o));
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_push_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(sp_o) - ADDR_W'(1)));
  assert_pop_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (sp_o == $past(sp_o) + ADDR_W'(1)));
  assert_pop_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> rf_we_o);
  assert_wb_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_re_o));
  assert_flags_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({zr_o, ng_o, uo_o, so_o}));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/regstack_seq_test.sv
module regstack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, pop = 1'b0, bank = 1'b0;
  logic [7:0]  mask = '0;
  logic [15:0] sp_in = '0;
  logic        busy, done, mem_we, mem_re, rf_we, zr, ng, uo, so;
  logic [15:0] sp_out, mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr;

  logic [15:0] mem_m [256];
  logic [15:0] rf_m  [16];
  logic [15:0] exp_mem [256];
  logic [15:0] exp_rf  [16];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  regstack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pop_i(pop), .mask_i(mask),
    .bank_hi_i(bank), .sp_i(sp_in), .busy_o(busy), .done_o(done), .sp_o(sp_out),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .zr_o(zr), .ng_o(ng), .uo_o(uo), .so_o(so)
  );

  assign rf_rdata = rf_m[rf_raddr];
  always @(posedge clk) begin
    if (mem_we) mem_m[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_m[mem_addr[7:0]];
    if (rf_we)  rf_m[rf_waddr] <= rf_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic run_op(input bit p, input bit b, input logic [7:0] m,
                        input logic [15:0] sp0, input bit poke);
    logic [15:0] q, last;
    int k, lat, exp_lat, bad;
    logic [3:0] fl_before;
    k = 0; last = '0; q = sp0;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem_m[i];
    for (int i = 0; i < 16; i++)  exp_rf[i]  = rf_m[i];
    fl_before = {zr, ng, uo, so};
    if (!p) begin
      for (int i = 0; i < 8; i++) if (m[i]) begin
        q = q - 16'd1; exp_mem[q[7:0]] = rf_m[{b, 3'(i)}]; last = rf_m[{b, 3'(i)}]; k++;
      end
    end else begin
      for (int i = 7; i >= 0; i--) if (m[i]) begin
        exp_rf[{b, 3'(i)}] = mem_m[q[7:0]]; last = mem_m[q[7:0]]; q = q + 16'd1; k++;
      end
    end
    exp_lat = (k == 0) ? 1 : (p ? k + 2 : k + 1);
    @(negedge clk);
    start = 1'b1; pop = p; bank = b; mask = m; sp_in = sp0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1 && poke) begin
        start = 1'b1; pop = !p; mask = ~m; bank = !b; sp_in = sp0 ^ 16'h0055;
      end else start = 1'b0;
    end while (!done && lat < 40);
    start = 1'b0;
    chk(lat == exp_lat, poke ? "R8" : "R4", "done latency", lat, exp_lat);
    if (k == 0)
      chk({zr, ng, uo, so} == fl_before, "R5", "flags unchanged", {zr, ng, uo, so}, fl_before);
    else
      chk({zr, ng, uo, so} == {last == 16'd0, last[15], 2'b00}, "R6", "flags",
          {zr, ng, uo, so}, {last == 16'd0, last[15], 2'b00});
    @(negedge clk);
    chk(!done && !busy, "R4", "done pulse width", {done, busy}, 0);
    chk(sp_out == (k == 0 ? sp0 : q), "R3", "final pointer", sp_out, q);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem_m[i] !== exp_mem[i]) bad++;
    chk(bad == 0, p ? "R7" : "R1", "memory image mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < 16; i++) if (rf_m[i] !== exp_rf[i]) bad++;
    chk(bad == 0, p ? "R2" : "R7", "register image mismatches", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem_m[i] = 16'($urandom);
    for (int i = 0; i < 16; i++)  rf_m[i]  = 16'h1000 + 16'(i * 16'h0111);
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({busy, done, zr, ng, uo, so, mem_we, mem_re, rf_we} == '0, "R9", "reset outputs",
        {busy, done, zr, ng, uo, so, mem_we, mem_re, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re && !rf_we, "R10", "idle quiet",
        {busy, mem_we, mem_re, rf_we}, 0);
    // directed R1: full lower bank save, then R2: restore it into cleared regs
    run_op(1'b0, 1'b0, 8'hFF, 16'h0080, 1'b0);
    for (int i = 0; i < 8; i++) rf_m[i] = 16'h0;
    run_op(1'b1, 1'b0, 8'hFF, 16'h0078, 1'b0);
    chk(rf_m[0] == 16'h1000 && rf_m[7] == 16'h1777, "R2", "round trip",
        {rf_m[0], rf_m[7]}, {16'h1000, 16'h1777});
    // R6: zero and negative final values; R7 upper bank
    rf_m[3] = 16'h0000;
    run_op(1'b0, 1'b0, 8'h0B, 16'h0040, 1'b0);
    rf_m[15] = 16'h8001;
    run_op(1'b0, 1'b1, 8'h81, 16'h0030, 1'b0);
    // R5: empty mask in both directions
    run_op(1'b0, 1'b1, 8'h00, 16'h0020, 1'b0);
    run_op(1'b1, 1'b0, 8'h00, 16'h0020, 1'b0);
    // single registers and pointer wrap
    run_op(1'b1, 1'b1, 8'h01, 16'hFFFF, 1'b0);
    run_op(1'b0, 1'b0, 8'h80, 16'h0000, 1'b0);
    // R8: start while busy
    run_op(1'b0, 1'b1, 8'h5A, 16'h0090, 1'b1);
    run_op(1'b1, 1'b0, 8'hA5, 16'h0060, 1'b1);
    run_op(1'b0, 1'b0, 8'h00, 16'h0050, 1'b1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      run_op(1'($urandom), 1'($urandom), 8'($urandom), 16'h0010 + 16'($urandom_range(0, 220)),
             ($urandom_range(0, 3) == 0));
    end
    summary();
  end
endmodule